// File: doc/BRIEF.md
# CAN Receive Message Queue with Host Window

This block holds received CAN frames between the protocol engine and the host. Storage is a ring of message slots, each fifteen bytes wide. One slot at a time is the collection slot. The engine writes the bytes of the frame it is receiving into that slot. At the same moment, identifier filtering runs outside this block. When the frame ends, the engine reports whether the frame completed without error and whether it matched the filter. Only a frame that passes both tests is committed. The next free slot then becomes the collection slot.

The host never sees the ring itself. It reads one fixed window of fifteen byte offsets, and that window always shows the oldest committed frame. A pending flag reports that the window holds a frame. When the host is done with the frame, it pulses a release input, which acts like writing one to the flag. The window then moves on to the next committed frame, and the flag stays set if another frame is waiting.

A committed frame that finds no free slot is dropped, and a sticky overrun flag is set. A dropped frame never overwrites anything the host can see. A receive interrupt follows the pending flag when the interrupt is enabled.

Top module: `can_rx_fifo`

## Requirements
- R1: After reset, rx_full, ovr_flag and rx_irq are all 0.
- R2: A frame commits when eng_frame_end is pulsed with both eng_frame_ok and eng_filter_hit set. The bytes written to offsets 0 to 14 of the collection slot are then readable at host_rd_addr 0 to 14. rx_full is 1 from the cycle after the commit.
- R3: A frame end with eng_frame_ok=0 or eng_filter_hit=0 is discarded. rx_full and the window contents do not change.
- R4: With NUM_BUF=5, up to four committed frames are held at once. They appear in the window in the order they were committed.
- R5: A host_release pulse while rx_full=1 retires the frame in the window and shows the next frame. rx_full then stays 1 if another frame is held and drops to 0 if none is. A release while rx_full=0 has no effect.
- R6: A frame that commits while four frames are already held, with no release in the same cycle, is dropped. This sets ovr_flag and leaves the window and all held frames unchanged.
- R7: ovr_flag stays set until host_ovr_clr is pulsed. If a drop and a clear happen in the same cycle, the flag stays set.
- R8: A commit and a release in the same cycle while four frames are held do not cause an overrun. The new frame is kept at the tail of the queue.
- R9: rx_irq equals rx_full AND irq_en.
- R10: host_rd_addr values 15 and above read as 0.
- R11: Byte writes into the collection slot never change the data shown in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_wr_en | input | 1 | Engine byte write strobe into the collection slot |
| eng_wr_addr | input | 4 | Byte offset within the slot |
| eng_wr_data | input | 8 | Byte value |
| eng_frame_end | input | 1 | One-cycle end-of-frame strobe |
| eng_frame_ok | input | 1 | Frame completed without error (qualified by eng_frame_end) |
| eng_filter_hit | input | 1 | Identifier passed the acceptance filter (qualified by eng_frame_end) |
| host_rd_addr | input | 4 | Byte offset within the host window |
| host_rd_data | output | 8 | Byte of the oldest held frame |
| host_release | input | 1 | Retire the frame in the window (write-one to the pending flag) |
| host_ovr_clr | input | 1 | Clear the overrun flag |
| irq_en | input | 1 | Receive interrupt enable |
| rx_full | output | 1 | Window holds a committed frame |
| ovr_flag | output | 1 | Sticky overrun indicator |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A wrong head pointer or occupancy count shows up as the wrong frame in the window, or as rx_full reporting the wrong state. This appears on the first read after the faulty commit or release, so the scoreboard compares all fifteen window bytes after every change. A collection pointer that lands on the window shows up as corrupted window bytes while the next frame is still being written. A wrong full-condition test shows up as an early or missing overrun on the fifth frame, and as lost data when the queue is drained.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

    // byte layout of one message slot
    localparam int SLOT_BYTES = 15;
    localparam int BYTE_W     = 8;

    // qualified end-of-frame event from the protocol engine
    typedef struct packed {
        logic stb;
        logic ok;
        logic hit;
    } frame_evt_t;

    function automatic logic evt_commits(input frame_evt_t e);
        return e.stb & e.ok & e.hit;
    endfunction

endpackage

// File: rtl/can_rxf_store.sv
module can_rxf_store #(
    parameter int NUM_BUF    = 5,
    parameter int SLOT_BYTES = 15,
    parameter int DW         = 8,
    parameter int AW         = 4,
    parameter int PTR_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_slot_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [PTR_W-1:0] rd_slot_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [DW-1:0]    rd_data_o
);

    localparam logic [AW-1:0] LAST_BYTE = AW'(SLOT_BYTES - 1);

    typedef logic [DW-1:0] slot_t [SLOT_BYTES];

    slot_t mem_d [NUM_BUF];
    slot_t mem_q [NUM_BUF];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i && (wr_addr_i <= LAST_BYTE)) begin
            mem_d[wr_slot_i][wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_BUF; s++) begin
                for (int b = 0; b < SLOT_BYTES; b++) begin
                    mem_q[s][b] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i <= LAST_BYTE) begin
            rd_data_o = mem_q[rd_slot_i][rd_addr_i];
        end
    end

endmodule

// File: rtl/can_rxf_ctrl.sv
module can_rxf_ctrl #(
    parameter int NUM_BUF = 5,
    parameter int PTR_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic             release_i,
    input  logic             ovr_clr_i,
    output logic [PTR_W-1:0] fg_slot_o,
    output logic [PTR_W-1:0] bg_slot_o,
    output logic             full_o,
    output logic             ovr_o
);

    localparam logic [PTR_W-1:0] HOLD_MAX = PTR_W'(NUM_BUF - 1);
    localparam logic [PTR_W:0]   RING_N   = (PTR_W + 1)'(NUM_BUF);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] count;
        logic             ovr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic           rel_ok;
    logic           room;
    logic           store;
    logic           drop;
    logic [PTR_W:0] bg_sum;

    always_comb begin
        st_d   = st_q;
        rel_ok = release_i && (st_q.count != '0);
        room   = (st_q.count < HOLD_MAX) || rel_ok;
        store  = commit_i && room;
        drop   = commit_i && !room;

        if (rel_ok) begin
            st_d.head = (st_q.head == HOLD_MAX) ? '0 : st_q.head + 1'b1;
        end

        unique case ({store, rel_ok})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase

        if (drop) begin
            st_d.ovr = 1'b1;
        end else if (ovr_clr_i) begin
            st_d.ovr = 1'b0;
        end

        bg_sum = {1'b0, st_q.head} + {1'b0, st_q.count};
        if (bg_sum >= RING_N) begin
            bg_sum = bg_sum - RING_N;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fg_slot_o = st_q.head;
    assign bg_slot_o = bg_sum[PTR_W-1:0];
    assign full_o    = (st_q.count != '0);
    assign ovr_o     = st_q.ovr;

endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
    import can_rxf_pkg::*;
#(
    parameter int NUM_BUF = 5,
    parameter int AW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_wr_en,
    input  logic [AW-1:0]     eng_wr_addr,
    input  logic [BYTE_W-1:0] eng_wr_data,
    input  logic              eng_frame_end,
    input  logic              eng_frame_ok,
    input  logic              eng_filter_hit,
    input  logic [AW-1:0]     host_rd_addr,
    output logic [BYTE_W-1:0] host_rd_data,
    input  logic              host_release,
    input  logic              host_ovr_clr,
    input  logic              irq_en,
    output logic              rx_full,
    output logic              ovr_flag,
    output logic              rx_irq
);

    localparam int PTR_W = (NUM_BUF > 2) ? $clog2(NUM_BUF) : 1;

    frame_evt_t       evt;
    logic             commit;
    logic [PTR_W-1:0] fg_slot;
    logic [PTR_W-1:0] bg_slot;

    assign evt    = '{stb: eng_frame_end, ok: eng_frame_ok, hit: eng_filter_hit};
    assign commit = evt_commits(evt);

    can_rxf_ctrl #(
        .NUM_BUF (NUM_BUF),
        .PTR_W   (PTR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .release_i (host_release),
        .ovr_clr_i (host_ovr_clr),
        .fg_slot_o (fg_slot),
        .bg_slot_o (bg_slot),
        .full_o    (rx_full),
        .ovr_o     (ovr_flag)
    );

    can_rxf_store #(
        .NUM_BUF    (NUM_BUF),
        .SLOT_BYTES (SLOT_BYTES),
        .DW         (BYTE_W),
        .AW         (AW),
        .PTR_W      (PTR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (eng_wr_en),
        .wr_slot_i (bg_slot),
        .wr_addr_i (eng_wr_addr),
        .wr_data_i (eng_wr_data),
        .rd_slot_i (fg_slot),
        .rd_addr_i (host_rd_addr),
        .rd_data_o (host_rd_data)
    );

    assign rx_irq = rx_full & irq_en;

endmodule

// File: rtl/can_rx_fifo_chk.sv
module can_rx_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic eng_frame_end,
    input logic eng_frame_ok,
    input logic eng_filter_hit,
    input logic host_release,
    input logic host_ovr_clr,
    input logic irq_en,
    input logic rx_full,
    input logic ovr_flag,
    input logic rx_irq
);

    logic good_end;
    assign good_end = eng_frame_end && eng_frame_ok && eng_filter_hit;

    p_full_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        good_end |=> rx_full);

    p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!good_end && !host_release) |=> $stable(rx_full));

    p_empty_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_full && host_release && !good_end) |=> !rx_full);

    p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_flag ##1 ovr_flag) |-> ($past(rx_full) && $past(good_end)));

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !host_ovr_clr) |=> ovr_flag);

    p_irq_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_full && irq_en));

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && irq_en) |-> rx_irq);

endmodule

bind can_rx_fifo can_rx_fifo_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .eng_frame_end  (eng_frame_end),
    .eng_frame_ok   (eng_frame_ok),
    .eng_filter_hit (eng_filter_hit),
    .host_release   (host_release),
    .host_ovr_clr   (host_ovr_clr),
    .irq_en         (irq_en),
    .rx_full        (rx_full),
    .ovr_flag       (ovr_flag),
    .rx_irq         (rx_irq)
);

// File: tb/can_rx_fifo_test.sv
module can_rx_fifo_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eng_wr_en = 1'b0;
    logic [3:0] eng_wr_addr = '0;
    logic [7:0] eng_wr_data = '0;
    logic       eng_frame_end = 1'b0;
    logic       eng_frame_ok = 1'b0;
    logic       eng_filter_hit = 1'b0;
    logic [3:0] host_rd_addr = '0;
    logic [7:0] host_rd_data;
    logic       host_release = 1'b0;
    logic       host_ovr_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       rx_full;
    logic       ovr_flag;
    logic       rx_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] sb_q[$];
    logic       exp_ovr = 1'b0;

    always #10 clk = ~clk;

    can_rx_fifo uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .eng_wr_en      (eng_wr_en),
        .eng_wr_addr    (eng_wr_addr),
        .eng_wr_data    (eng_wr_data),
        .eng_frame_end  (eng_frame_end),
        .eng_frame_ok   (eng_frame_ok),
        .eng_filter_hit (eng_filter_hit),
        .host_rd_addr   (host_rd_addr),
        .host_rd_data   (host_rd_data),
        .host_release   (host_release),
        .host_ovr_clr   (host_ovr_clr),
        .irq_en         (irq_en),
        .rx_full        (rx_full),
        .ovr_flag       (ovr_flag),
        .rx_irq         (rx_irq)
    );

    task automatic check(input bit cond, input string req, input int act, input int expv);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_flags(input string req);
        check(rx_full == (sb_q.size() != 0), req, int'(rx_full), int'(sb_q.size() != 0));
        check(ovr_flag == exp_ovr, req, int'(ovr_flag), int'(exp_ovr));
    endtask

    // monitor side: compare the window against the oldest expected frame
    task automatic check_window(input string req);
        logic [7:0] seed;
        if (sb_q.size() == 0) return;
        seed = sb_q[0];
        for (int i = 0; i < 15; i++) begin
            host_rd_addr = 4'(i);
            #1;
            check(host_rd_data == seed + 8'(i), req, int'(host_rd_data), int'(seed + 8'(i)));
        end
    endtask

    // driver: write a frame into the collection slot and end it
    task automatic send_frame(input logic [7:0] seed, input logic ok, input logic hit,
                              input logic rel, input logic clr);
        int had;
        bit rel_ok;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            eng_wr_en   = 1'b1;
            eng_wr_addr = 4'(i);
            eng_wr_data = seed + 8'(i);
        end
        @(negedge clk);
        eng_wr_en      = 1'b0;
        eng_frame_end  = 1'b1;
        eng_frame_ok   = ok;
        eng_filter_hit = hit;
        host_release   = rel;
        host_ovr_clr   = clr;
        had    = sb_q.size();
        rel_ok = rel && (had > 0);
        if (rel_ok) void'(sb_q.pop_front());
        if (ok && hit && !(had < 4 || rel_ok)) exp_ovr = 1'b1;
        else if (clr) exp_ovr = 1'b0;
        if (ok && hit && (had < 4 || rel_ok)) sb_q.push_back(seed);
        @(negedge clk);
        eng_frame_end  = 1'b0;
        eng_frame_ok   = 1'b0;
        eng_filter_hit = 1'b0;
        host_release   = 1'b0;
        host_ovr_clr   = 1'b0;
    endtask

    task automatic release_one(input string req);
        @(negedge clk);
        host_release = 1'b1;
        if (sb_q.size() > 0) void'(sb_q.pop_front());
        @(negedge clk);
        host_release = 1'b0;
        check_flags(req);
        check_window(req);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_full == 1'b0, "R1 rx_full", int'(rx_full), 0);
        check(ovr_flag == 1'b0, "R1 ovr_flag", int'(ovr_flag), 0);
        check(rx_irq == 1'b0, "R1 rx_irq", int'(rx_irq), 0);

        // R2 single frame commits
        send_frame(8'h10, 1'b1, 1'b1, 1'b0, 1'b0);
        check_flags("R2");
        check_window("R2");

        // R3 rejected frames: filter miss, then error
        send_frame(8'h80, 1'b1, 1'b0, 1'b0, 1'b0);
        check_flags("R3 filter miss");
        check_window("R3 filter miss");
        send_frame(8'h90, 1'b0, 1'b1, 1'b0, 1'b0);
        check_flags("R3 error frame");
        check_window("R3 error frame");

        // R9 interrupt gating
        check(rx_irq == 1'b0, "R9 disabled", int'(rx_irq), 0);
        irq_en = 1'b1;
        #1;
        check(rx_irq == 1'b1, "R9 enabled", int'(rx_irq), 1);

        // R10 out-of-range read
        host_rd_addr = 4'd15;
        #1;
        check(host_rd_data == 8'h00, "R10", int'(host_rd_data), 0);

        // R4 / R11 fill to four held frames, window stays on the first
        send_frame(8'h20, 1'b1, 1'b1, 1'b0, 1'b0);
        check_window("R11 second");
        send_frame(8'h30, 1'b1, 1'b1, 1'b0, 1'b0);
        check_window("R11 third");
        send_frame(8'h40, 1'b1, 1'b1, 1'b0, 1'b0);
        check_flags("R4 four held");
        check_window("R11 fourth");

        // R6 overrun drop
        send_frame(8'h50, 1'b1, 1'b1, 1'b0, 1'b0);
        check_flags("R6 overrun");
        check_window("R6 window kept");

        // R7 sticky, then cleared
        repeat (3) @(negedge clk);
        check(ovr_flag == 1'b1, "R7 sticky", int'(ovr_flag), 1);
        host_ovr_clr = 1'b1;
        exp_ovr = 1'b0;
        @(negedge clk);
        host_ovr_clr = 1'b0;
        check_flags("R7 cleared");

        // R7 drop wins over same-cycle clear
        send_frame(8'h60, 1'b1, 1'b1, 1'b0, 1'b1);
        check(ovr_flag == 1'b1, "R7 set beats clear", int'(ovr_flag), 1);
        host_ovr_clr = 1'b1;
        exp_ovr = 1'b0;
        @(negedge clk);
        host_ovr_clr = 1'b0;

        // R8 commit together with release while holding four
        send_frame(8'hA0, 1'b1, 1'b1, 1'b1, 1'b0);
        check_flags("R8 no overrun");
        check_window("R8 window advanced");

        // R4 / R5 drain in order
        release_one("R5 drain a");
        release_one("R5 drain b");
        release_one("R4 drain c");
        release_one("R5 last");
        check(rx_irq == 1'b0, "R9 empty", int'(rx_irq), 0);

        // R5 release while empty is ignored
        release_one("R5 empty release");
        send_frame(8'hC0, 1'b1, 1'b1, 1'b0, 1'b0);
        check_flags("R5 after empty release");
        check_window("R5 after empty release");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule